// File: doc/BRIEF.md
# Page Write Buffer with Deferred Commit

This block sits between a serial-bus slave front end and a non-volatile storage array. The front end decodes the protocol and passes on simple strobes: one that loads a starting byte address, one for each received data byte, one when the transaction closes with a Stop, and one when a new Start arrives first. Incoming bytes collect in an eight-entry page latch. Nothing is written to the array until the Stop.

The lower address bits work as a byte counter that wraps inside a fixed page. The upper bits select the page and never change during a transaction. A master that sends more than one page of data therefore overwrites its own earlier bytes, and the array receives only the most recent byte for each page position. Each latch entry carries a valid mark. Positions that were never sent keep their old array contents.

On a Stop with write protection low and at least one byte buffered, the block writes the marked entries to the array, one per clock. It holds a busy flag for a parameterised write-cycle time, counted in clock cycles. While the flag is high the block accepts no new address or data.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` is low, `arr_we` is low and no buffered bytes are pending.
- R2: A data byte goes to page position (start offset + byte index) mod 8. The start offset is `addr_in[2:0]` at the address load, and the page is `addr_in[7:3]`. The page does not change until the next address load.
- R3: When more than 8 bytes arrive before a Stop, each page position holds the last byte sent to it.
- R4: `arr_we` stays low until a Stop is accepted. Once busy ends, every buffered byte has been written.
- R5: A commit writes only the positions that received a byte in this transaction. Other addresses, in this page and in other pages, keep their contents. There is exactly one array write per such position.
- R6: A Stop with `wp_level` low and at least one buffered byte raises `busy` on the next cycle. `busy` then stays high for exactly `WRITE_CYCLES` cycles.
- R7: If `wp_level` is high when the Stop is accepted, nothing is written, `busy` stays low and the buffered bytes are discarded. A later Stop then has nothing to commit.
- R8: An abort strobe discards every buffered byte. A following Stop writes nothing and raises no `busy`.
- R9: While `busy` is high, address-load and data-byte strobes have no effect on the buffer, the page or the byte counter.
- R10: A Stop with no buffered byte, as at the end of a read, raises no `busy` and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load start address strobe |
| addr_in | input | ADDR_W | Start byte address |
| byte_valid | input | 1 | Data byte strobe |
| byte_in | input | DATA_W | Data byte |
| stop_strobe | input | 1 | Transaction ended with Stop |
| abort_strobe | input | 1 | Transaction interrupted by a new Start |
| wp_level | input | 1 | Write-protect level, sampled at Stop |
| arr_we | output | 1 | Array byte write request |
| arr_addr | output | ADDR_W | Array byte address |
| arr_data | output | DATA_W | Array byte data |
| busy | output | 1 | Write cycle in progress |

## Verification
The hardest case to reach is a strobe arriving while a commit is in progress. To show it has no effect, the bench must prove afterwards that the page register and the byte counter are unchanged. The stimulus does this in three steps. It starts a commit and, while busy is high, loads a different address and sends a byte. After busy drops, it sends one more byte with no new address load, then a Stop. That byte must land one position after the last byte of the previous transaction, and the address and byte sent during busy must leave no trace in the array. Wrap-around and overflow are driven from the vector table, with start offsets near the end of a page and with more than eight bytes.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_strobe,
  input  logic              abort_strobe,
  input  logic              wp_level,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFS_W;
  localparam int SLOT_W = OFS_W + 1;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [BASE_W-1:0]                  page_base;
  logic [OFS_W-1:0]                   ptr;
  logic [PAGE_BYTES-1:0][DATA_W-1:0]  pbuf;
  logic [PAGE_BYTES-1:0]              dirty;
  logic [CNT_W-1:0]                   cnt;
  logic [SLOT_W-1:0]                  slot;

  wire              slot_live = slot < SLOT_W'(PAGE_BYTES);
  wire [OFS_W-1:0]  slot_idx  = slot[OFS_W-1:0];

  assign arr_we   = busy && slot_live && dirty[slot_idx];
  assign arr_addr = {page_base, slot_idx};
  assign arr_data = pbuf[slot_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_base <= '0;
      ptr       <= '0;
      pbuf      <= '0;
      dirty     <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      slot      <= '0;
    end else if (busy) begin
      if (slot_live) begin
        dirty[slot_idx] <= 1'b0;
        slot            <= slot + 1'b1;
      end
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (abort_strobe) begin
      dirty <= '0;
    end else if (stop_strobe) begin
      if (wp_level) begin
        dirty <= '0;
      end else if (|dirty) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(WRITE_CYCLES - 1);
        slot <= '0;
      end
    end else if (addr_load) begin
      page_base <= addr_in[ADDR_W-1:OFS_W];
      ptr       <= addr_in[OFS_W-1:0];
    end else if (byte_valid) begin
      pbuf[ptr]  <= byte_in;
      dirty[ptr] <= 1'b1;
      ptr        <= ptr + 1'b1;
    end
  end

  // R7
  wp_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_strobe && !abort_strobe && !busy && wp_level |=> !busy && dirty == '0);

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_strobe && !busy |=> dirty == '0);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_strobe && !wp_level && !abort_strobe));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pbuf) && $stable(page_base) && $stable(ptr));

  // R4
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> dirty == '0);
endmodule

// File: tb/page_write_buffer_bench.sv
module page_write_buffer_bench;
  localparam int WC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0, byte_valid = 1'b0, stop_strobe = 1'b0;
  logic       abort_strobe = 1'b0, wp_level = 1'b0;
  logic [7:0] addr_in = '0, byte_in = '0;
  logic       arr_we, busy;
  logic [7:0] arr_addr, arr_data;

  always #2.5 clk = ~clk;

  page_write_buffer #(.ADDR_W(8), .DATA_W(8), .PAGE_BYTES(8), .WRITE_CYCLES(WC)) u_page_write_buffer (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_in(byte_in), .stop_strobe(stop_strobe),
    .abort_strobe(abort_strobe), .wp_level(wp_level), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy));

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int we_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) if (arr_we) begin
    mem[arr_addr] <= arr_data;
    we_cnt <= we_cnt + 1;
  end

  // {start address, byte count, write protect, first data value}
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'd1,  8'd0, 8'h11},
    {8'h10, 8'd8,  8'd0, 8'h20},
    {8'h2D, 8'd5,  8'd0, 8'h40},
    {8'h50, 8'd11, 8'd0, 8'h60},
    {8'h70, 8'd3,  8'd1, 8'h80},
    {8'hF6, 8'd4,  8'd0, 8'h90}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] a);
    @(negedge clk); addr_in = a; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); byte_in = d; byte_valid = 1'b1;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic do_stop(input bit wp);
    @(negedge clk); wp_level = wp; stop_strobe = 1'b1;
    @(negedge clk); stop_strobe = 1'b0; wp_level = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort_strobe = 1'b1;
    @(negedge clk); abort_strobe = 1'b0;
  endtask

  task automatic wait_idle(output int d);
    d = 0;
    while (busy) begin d++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, w0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      ref_mem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && arr_we == 1'b0, "R1 idle after reset", {busy, arr_we}, 0);

    // R10: Stop with empty buffer
    w0 = we_cnt;
    do_stop(1'b0);
    chk(busy == 1'b0, "R10 no busy", busy, 0);
    repeat (10) @(negedge clk);
    chk(we_cnt == w0, "R10 no writes", we_cnt - w0, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] a, n, s;
      bit wp;
      int distinct;
      a = VEC[v][31:24]; n = VEC[v][23:16]; wp = VEC[v][8]; s = VEC[v][7:0];
      w0 = we_cnt;
      do_load(a);
      for (int i = 0; i < int'(n); i++) do_byte(8'(s + 8'(i)));
      repeat (3) @(negedge clk);
      chk(we_cnt == w0, "R4 no write before stop", we_cnt - w0, 0);
      do_stop(wp);
      chk(busy == !wp, wp ? "R7 no busy under protect" : "R6 busy after stop", busy, !wp);
      wait_idle(d);
      if (!wp) chk(d == WC, "R6 busy length", d, WC);
      if (!wp)
        for (int i = 0; i < int'(n); i++)
          ref_mem[{a[7:3], 3'(a[2:0] + 3'(i))}] = 8'(s + 8'(i));
      distinct = wp ? 0 : ((n > 8) ? 8 : int'(n));
      chk(we_cnt - w0 == distinct, "R5 write count", we_cnt - w0, distinct);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] ad;
        ad = {a[7:3], 3'(k)};
        chk(mem[ad] == ref_mem[ad], (n > 8) ? "R3 page contents" : "R2 page contents",
            mem[ad], ref_mem[ad]);
      end
      chk(mem[8'(a + 8'd8)] == ref_mem[8'(a + 8'd8)], "R5 next page untouched",
          mem[8'(a + 8'd8)], ref_mem[8'(a + 8'd8)]);
    end

    // R7: protected Stop discards buffer
    w0 = we_cnt;
    do_load(8'h80); do_byte(8'h01); do_byte(8'h02);
    do_stop(1'b1);
    chk(busy == 1'b0, "R7 no busy", busy, 0);
    do_stop(1'b0);
    chk(busy == 1'b0, "R7 buffer discarded", busy, 0);
    repeat (10) @(negedge clk);
    chk(we_cnt == w0 && mem[8'h80] == ref_mem[8'h80], "R7 array unchanged", mem[8'h80], ref_mem[8'h80]);

    // R8: abort
    do_load(8'h90); do_byte(8'h07); do_byte(8'h08); do_byte(8'h09);
    do_abort();
    do_stop(1'b0);
    chk(busy == 1'b0, "R8 no busy after abort", busy, 0);
    repeat (10) @(negedge clk);
    chk(we_cnt == w0 && mem[8'h90] == ref_mem[8'h90], "R8 array unchanged", mem[8'h90], ref_mem[8'h90]);

    // R9: strobes ignored while busy
    do_load(8'hA0); do_byte(8'h31); do_byte(8'h32);
    do_stop(1'b0);
    ref_mem[8'hA0] = 8'h31; ref_mem[8'hA1] = 8'h32;
    do_load(8'hC0); do_byte(8'hEE);
    chk(busy == 1'b1, "R9 still busy", busy, 1);
    wait_idle(d);
    do_byte(8'h55);
    do_stop(1'b0);
    ref_mem[8'hA2] = 8'h55;
    wait_idle(d);
    chk(mem[8'hA2] == 8'h55, "R9 pointer kept", mem[8'hA2], 8'h55);
    chk(mem[8'hC0] == ref_mem[8'hC0], "R9 busy load ignored", mem[8'hC0], ref_mem[8'hC0]);
    chk(mem[8'hA0] == 8'h31 && mem[8'hA1] == 8'h32, "R9 earlier bytes", mem[8'hA0], 8'h31);
    chk(mem[8'hA3] == ref_mem[8'hA3], "R9 busy byte ignored", mem[8'hA3], ref_mem[8'hA3]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule